// File: doc/BRIEF.md
# Coprocessor Availability Fault Checker

This block sits in the issue stage of a simple processor model. Every cycle it looks at the instruction being issued and decides whether that instruction must take the "coprocessor not available" fault. Three configuration flags drive the decision. `emulate_en` means floating-point work is emulated in software. `monitor_cop` extends the stale-context check to WAIT. `ctx_stale` records that a task switch happened without saving the floating-point and vector register context.

The block keeps `ctx_stale` itself. A task-switch pulse sets it and a clear strobe from the handler resets it. Once the handler has saved the context and cleared the flag, the same instruction can issue again and runs without a fault.

When an instruction faults, the block raises a one-cycle registered fault pulse. It also asserts a matching execute-suppress, so the instruction leaves no architectural effect. It reports fault vector 7, with no error code, and returns the address of the faulting instruction itself.

Top module: `copro_avail_check`

## Requirements
- R1: Class codes on `issue_class` are 0 plain integer, 1 floating-point, 2 WAIT, 3 packed-integer, 4 vector; codes 5 to 7 behave as plain. A floating-point instruction (class 1) issued while `emulate_en` is 1 faults.
- R2: A WAIT instruction (class 2) faults when `monitor_cop` and `ctx_stale` are both 1, whatever `emulate_en` is. When `monitor_cop` is 0, WAIT never faults.
- R3: A floating-point, packed-integer or vector instruction (class 1, 3 or 4) issued while `ctx_stale` is 1 and `emulate_en` is 0 faults, unless R4 exempts it.
- R4: `issue_exempt` marks the fence, pause, prefetch, non-temporal integer store and cache-line flush operations. It stops the stale-context fault for classes 3 and 4. It has no effect on class 1.
- R5: `flt_valid` and `exec_suppress` go high together in the cycle after a faulting issue, for exactly one cycle per faulting issue. Alongside them, `flt_vector` reads 7.
- R6: `flt_addr` equals the `issue_addr` of the faulting instruction. `flt_addr` and `flt_vector` hold their values until the next fault.
- R7: A `task_switch` pulse sets `ctx_stale` on the next edge and `ts_clear` clears it; if both arrive in the same cycle, the set wins. An issue in the same cycle sees the value from before the edge.
- R8: After reset, `flt_valid`, `exec_suppress` and `ctx_stale` are 0, and `flt_vector` and `flt_addr` are 0.
- R9: `flt_has_code` is always 0. Plain-class instructions (codes 0, 5, 6, 7) and cycles with `issue_valid` low never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_class | input | 3 | Instruction class code (see R1) |
| issue_exempt | input | 1 | Opcode is exempt from the stale-context check |
| issue_addr | input | ADDR_W | Address of the issuing instruction |
| emulate_en | input | 1 | Floating-point emulation flag |
| monitor_cop | input | 1 | Enables the stale-context check for WAIT |
| task_switch | input | 1 | Task-switch pulse, sets `ctx_stale` |
| ts_clear | input | 1 | Handler strobe, clears `ctx_stale` |
| flt_valid | output | 1 | Fault pulse |
| flt_vector | output | VEC_W | Fault vector number |
| flt_has_code | output | 1 | Error code present (always 0) |
| flt_addr | output | ADDR_W | Saved address of the faulting instruction |
| exec_suppress | output | 1 | Blocks execution of the faulting instruction |
| ctx_stale | output | 1 | Current stale-context flag |

## Verification
The assertions assume that `task_switch` and `ts_clear` are ordinary synchronous inputs. Their only promise about timing is that a set wins over a clear.

The assertions also assume that `issue_class` and the flags are meaningful only when `issue_valid` is high. The stimulus therefore drives every input from random values away from the clock edge, including the unused class codes and exempt flags on classes that ignore them, so every combination is legal.

Directed sequences cover the handler restart, a simultaneous set and clear, and issues in the same cycle as a flag change.

// File: rtl/copro_avail_check.sv
module copro_avail_check #(
  parameter int ADDR_W  = 32,
  parameter int VEC_W   = 8,
  parameter int VEC_NUM = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [2:0]        issue_class,
  input  logic              issue_exempt,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              emulate_en,
  input  logic              monitor_cop,
  input  logic              task_switch,
  input  logic              ts_clear,
  output logic              flt_valid,
  output logic [VEC_W-1:0]  flt_vector,
  output logic              flt_has_code,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              exec_suppress,
  output logic              ctx_stale
);

  localparam logic [2:0] CLS_FP   = 3'd1;
  localparam logic [2:0] CLS_WAIT = 3'd2;
  localparam logic [2:0] CLS_PKD  = 3'd3;
  localparam logic [2:0] CLS_VEC  = 3'd4;
  localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(VEC_NUM);

  logic is_fp, is_wait, is_simd;
  logic trap_emul, trap_wait, trap_ctx, trap;

  assign is_fp   = issue_class == CLS_FP;
  assign is_wait = issue_class == CLS_WAIT;
  assign is_simd = (issue_class == CLS_PKD) || (issue_class == CLS_VEC);

  assign trap_emul = is_fp & emulate_en;
  assign trap_wait = is_wait & monitor_cop & ctx_stale;
  assign trap_ctx  = (is_fp | (is_simd & ~issue_exempt)) & ctx_stale & ~emulate_en;
  assign trap      = issue_valid & (trap_emul | trap_wait | trap_ctx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctx_stale <= 1'b0;
    else if (task_switch) ctx_stale <= 1'b1;
    else if (ts_clear)    ctx_stale <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid  <= 1'b0;
      flt_vector <= '0;
      flt_addr   <= '0;
    end else begin
      flt_valid <= trap;
      if (trap) begin
        flt_vector <= VEC_CODE;
        flt_addr   <= issue_addr;
      end
    end
  end

  assign exec_suppress = flt_valid;
  assign flt_has_code  = 1'b0;

  p_emul_fp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_fp && emulate_en |=> flt_valid);

  p_wait_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_wait && monitor_cop && ctx_stale |=> flt_valid);

  p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_wait && !monitor_cop |=> !flt_valid);

  p_simd_stale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_simd && !issue_exempt && ctx_stale && !emulate_en |=> flt_valid);

  p_exempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_simd && issue_exempt |=> !flt_valid);

  p_needs_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !flt_valid);

  p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> flt_addr == $past(issue_addr));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> $stable(flt_addr) || flt_valid);

  p_ts_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ctx_stale);

  p_ts_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clear && !task_switch |=> !ctx_stale);

endmodule

// File: tb/test_copro_avail_check.sv
module test_copro_avail_check;
  localparam int ADDR_W = 32;
  localparam int VEC_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [2:0] issue_class = '0;
  logic issue_exempt = 1'b0;
  logic [ADDR_W-1:0] issue_addr = '0;
  logic emulate_en = 1'b0, monitor_cop = 1'b0, task_switch = 1'b0, ts_clear = 1'b0;
  logic flt_valid, flt_has_code, exec_suppress, ctx_stale;
  logic [VEC_W-1:0] flt_vector;
  logic [ADDR_W-1:0] flt_addr;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit m_ts = 0;
  logic [VEC_W-1:0] m_vec = '0;
  logic [ADDR_W-1:0] m_addr = '0;

  always #2 clk = ~clk;

  copro_avail_check #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_copro_avail_check (
    .clk, .rst_n, .issue_valid, .issue_class, .issue_exempt, .issue_addr,
    .emulate_en, .monitor_cop, .task_switch, .ts_clear,
    .flt_valid, .flt_vector, .flt_has_code, .flt_addr, .exec_suppress, .ctx_stale);

  function automatic bit exp_fault(bit v, logic [2:0] c, bit ex, bit em, bit mp, bit ts);
    bit simd = (c == 3'd3) || (c == 3'd4);
    if (!v) return 0;
    if (c == 3'd1 && em) return 1;
    if (c == 3'd2) return mp && ts;
    if ((c == 3'd1 || (simd && !ex)) && ts && !em) return 1;
    return 0;
  endfunction

  function automatic string rule_tag(logic [2:0] c, bit ex, bit em);
    if (c == 3'd2) return "R2";
    if (c == 3'd1 && em) return "R1";
    if ((c == 3'd3 || c == 3'd4) && ex) return "R4";
    if (c == 3'd1 || c == 3'd3 || c == 3'd4) return "R3";
    return "R9";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] c, bit ex, logic [ADDR_W-1:0] a,
                      bit em, bit mp, bit tsw, bit clr);
    bit f;
    string tag;
    issue_valid = v; issue_class = c; issue_exempt = ex; issue_addr = a;
    emulate_en = em; monitor_cop = mp; task_switch = tsw; ts_clear = clr;
    f = exp_fault(v, c, ex, em, mp, m_ts);
    tag = v ? rule_tag(c, ex, em) : "R9";
    @(posedge clk);
    if (tsw) m_ts = 1; else if (clr) m_ts = 0;
    if (f) begin m_vec = 8'd7; m_addr = a; end
    @(negedge clk);
    check(tag, flt_valid, f);
    check("R5", exec_suppress, f);
    check("R6", flt_vector, m_vec);
    check("R6", flt_addr, m_addr);
    check("R7", ctx_stale, m_ts);
    check("R9", flt_has_code, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    if (!finished) begin
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R8", flt_valid, 0);
    check("R8", exec_suppress, 0);
    check("R8", ctx_stale, 0);
    check("R8", flt_vector, 0);
    check("R8", flt_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 emulated floating-point, R2 WAIT with monitor off stays quiet
    step(1, 3'd1, 0, 32'h100, 1, 0, 0, 0);
    step(1, 3'd2, 0, 32'h104, 1, 0, 0, 0);
    // R7 task switch; issue in same cycle sees old flag
    step(1, 3'd3, 0, 32'h108, 0, 1, 1, 0);
    step(1, 3'd3, 0, 32'h10c, 0, 1, 0, 0);
    step(1, 3'd4, 1, 32'h110, 0, 1, 0, 0);
    step(1, 3'd1, 1, 32'h114, 0, 1, 0, 0);
    step(1, 3'd2, 0, 32'h118, 1, 1, 0, 0);
    step(1, 3'd2, 0, 32'h11c, 1, 0, 0, 0);
    step(0, 3'd1, 0, 32'h120, 0, 1, 0, 0);
    step(1, 3'd6, 0, 32'h124, 1, 1, 0, 0);
    // handler restart: clear then reissue without fault
    step(0, 3'd0, 0, 32'h0, 0, 1, 0, 1);
    step(1, 3'd3, 0, 32'h10c, 0, 1, 0, 0);
    // R7 set wins over clear
    step(0, 3'd0, 0, 32'h0, 0, 1, 1, 1);
    step(1, 3'd4, 0, 32'h200, 0, 1, 1, 1);
    step(1, 3'd4, 0, 32'h204, 0, 1, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 9) < 8, 3'($urandom_range(0, 7)), 1'($urandom),
           $urandom, 1'($urandom), 1'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 6) == 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule